// File: doc/BRIEF.md
# Presentation Timestamp Offset Generator

This block produces the 16-bit presentation timestamp that goes with each bus cycle of an isochronous audio stream. A timestamp packs a 4-bit cycle number into the upper bits and a 12-bit tick position into the lower bits. A bus cycle is 3072 ticks long, and there are 8000 cycles per second, so a tick runs at 24.576 MHz. On every cycle strobe the block moves a running sample-event offset forward by one step. When that offset lands inside the current cycle, the block adds a fixed transfer delay and emits a timestamp. Otherwise it emits the reserved no-information code 0xFFFF.

A start pulse latches the sample-rate code and the blocking flag, and it resets the offset state. The rate code is 3 bits: 0 = 32 kHz, 1 = 44.1 kHz, 2 = 48 kHz, 3 = 88.2 kHz, 4 = 96 kHz, 5 = 176.4 kHz, 6 = 192 kHz. Code 7 is reserved and behaves like 6. The odd codes form the 44.1 kHz family. In that family the block steps by 1386 or 1387 ticks along a 147-entry phase pattern. This reproduces the exactly rounded event spacing without any divider. The division of the delayed offset by 3072 is done by a bank of comparators against multiples of 3072.

Top module: `syt_stamp_gen`

## Requirements
- R1: After reset `syt` is 0xFFFF and both `syt_val` and `syt_none` are low. Strobes give no result until the first start pulse.
- R2: Each strobe taken while started, and not in the same cycle as `start`, raises exactly one of `syt_val` or `syt_none`. That flag is high for one cycle only, on the clock edge that samples the strobe. A strobe in the same cycle as `start` is dropped.
- R3: Start sets the previous offset to 3072. On each strobe, a previous offset below 3072 is increased by the rate's step, and a previous offset of 3072 or more is reduced by 3072. The first strobe after a start therefore yields offset 0.
- R4: The step is 3072 ticks for code 0 and 1024 ticks for codes 2, 4 and 6.
- R5: For codes 1, 3 and 5 the step is 1386 plus an extra tick. The extra tick is added when (phase mod 13) is nonzero and a multiple of 4, or when phase equals 146. The phase starts at 67 on start, advances only on strobes that add a step, and wraps from 146 to 0.
- R6: When the new offset is below 3072, the delay is added to it to give D. The output is `syt` = ((cyc_count + D div 3072) << 12) + (D mod 3072), truncated to 16 bits, with `syt_val` high. Bits 11:0 are always below 3072.
- R7: The delay is 8704 ticks when non-blocking. When blocking it is 14848 for code 0, 13162 for the 44.1 kHz family, and 12800 for the 48 kHz family.
- R8: When the new offset is 3072 or more, `syt` is 0xFFFF and `syt_none` is high.
- R9: Only the low 4 bits of cycle count plus quotient survive, so the cycle number wraps modulo 16.
- R10: Rate code and blocking are sampled only at start. Changing them between starts has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch configuration and reset offset state |
| cyc_stb | input | 1 | One pulse per bus cycle |
| cyc_count | input | CYC_W | Current bus cycle count |
| rate_code | input | 3 | Sample-rate code, sampled at start |
| blocking | input | 1 | Blocking transmission mode, sampled at start |
| syt | output | 16 | Timestamp or 0xFFFF |
| syt_val | output | 1 | Valid timestamp this cycle |
| syt_none | output | 1 | No-information code this cycle |

## Verification
Every rate code is run in both modes against an arithmetic model that uses true division. One 44.1 kHz run is long enough to cross the phase wrap at 146. A design that handles the extra-tick rule or the wrap wrongly drifts by one tick and fails there. A run starting near the top of the cycle count catches a cycle number that does not wrap modulo 16. Rate and mode are toggled after each start, so a design that reads them live gives the wrong delay or step. Two further checks target the first strobe and a strobe that coincides with start: a wrong initial offset gives a stray no-info or a shifted tick, and a strobe that is not dropped with start shows up as a spurious output.

// File: rtl/syt_pkg.sv
package syt_pkg;

    localparam int TICKS_PER_CYC = 3072;
    localparam int OFF_W         = 13;
    localparam int SUM_W         = 15;
    localparam int SYT_W         = 16;
    localparam int CNO_W         = 4;
    localparam int TPOS_W        = SYT_W - CNO_W;
    localparam int MAXQ          = 7;

    localparam int PHASE_LAST    = 146;
    localparam int PHASE_INIT    = 67;
    localparam int IDX_INIT      = PHASE_INIT % 13;
    localparam int STEP44_BASE   = 1386;

    localparam int DLY_PLAIN     = 8704;
    localparam int DLY_BLK_32    = 14848;
    localparam int DLY_BLK_44    = 13162;
    localparam int DLY_BLK_48    = 12800;

    localparam logic [SYT_W-1:0] SYT_EMPTY = '1;

    typedef enum logic [2:0] {
        RC_32K   = 3'd0,
        RC_44K1  = 3'd1,
        RC_48K   = 3'd2,
        RC_88K2  = 3'd3,
        RC_96K   = 3'd4,
        RC_176K4 = 3'd5,
        RC_192K  = 3'd6,
        RC_RSVD  = 3'd7
    } rate_e;

    typedef struct packed {
        logic             fam44;
        logic [OFF_W-1:0] step;
        logic [SUM_W-1:0] delay;
    } rate_cfg_t;

    function automatic rate_cfg_t cfg_of(input logic [2:0] rc, input logic blk);
        rate_cfg_t c;
        c.fam44 = rc[0] && (rc != RC_RSVD);
        c.step  = (rc == RC_32K) ? OFF_W'(TICKS_PER_CYC) : OFF_W'(1024);
        if (!blk)
            c.delay = SUM_W'(DLY_PLAIN);
        else if (rc == RC_32K)
            c.delay = SUM_W'(DLY_BLK_32);
        else if (c.fam44)
            c.delay = SUM_W'(DLY_BLK_44);
        else
            c.delay = SUM_W'(DLY_BLK_48);
        return c;
    endfunction

endpackage

// File: rtl/syt_rate_cfg.sv
module syt_rate_cfg
    import syt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic [2:0] rate_code,
    input  logic      blocking,
    output rate_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg <= cfg_of(RC_48K, 1'b0);
        else if (load)
            cfg <= cfg_of(rate_code, blocking);
    end
endmodule

// File: rtl/syt_offset_track.sv
module syt_offset_track
    import syt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic             fam44,
    input  logic [OFF_W-1:0] step,
    output logic [OFF_W-1:0] nxt_off,
    output logic             nxt_in_cyc
);
    logic [OFF_W-1:0] last_off;
    logic [7:0]       phase;
    logic [3:0]       idx;
    logic             stepping;
    logic             extra;
    logic [OFF_W-1:0] inc;

    always_comb begin
        stepping = (last_off < OFF_W'(TICKS_PER_CYC));
        extra    = ((idx != 4'd0) && (idx[1:0] == 2'b00)) || (phase == 8'(PHASE_LAST));
        inc      = fam44 ? OFF_W'(STEP44_BASE) + OFF_W'(extra) : step;
        if (stepping)
            nxt_off = last_off + inc;
        else
            nxt_off = last_off - OFF_W'(TICKS_PER_CYC);
        nxt_in_cyc = (nxt_off < OFF_W'(TICKS_PER_CYC));
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            last_off <= OFF_W'(TICKS_PER_CYC);
            phase    <= 8'(PHASE_INIT);
            idx      <= 4'(IDX_INIT);
        end else if (adv) begin
            last_off <= nxt_off;
            if (stepping && fam44) begin
                if (phase == 8'(PHASE_LAST)) begin
                    phase <= '0;
                    idx   <= '0;
                end else begin
                    phase <= phase + 8'd1;
                    idx   <= (idx == 4'd12) ? 4'd0 : idx + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/syt_tick_split.sv
module syt_tick_split
    import syt_pkg::*;
#(
    parameter int QMAX = MAXQ,
    localparam int QW  = $clog2(QMAX + 1)
) (
    input  logic [SUM_W-1:0]  sum,
    output logic [QW-1:0]     quo,
    output logic [TPOS_W-1:0] rem
);
    logic [QMAX-1:0] ge;

    for (genvar k = 1; k <= QMAX; k++) begin : g_thr
        assign ge[k-1] = (sum >= SUM_W'(k * TICKS_PER_CYC));
    end

    logic [SUM_W-1:0] sub;

    always_comb begin
        quo = '0;
        for (int i = 0; i < QMAX; i++)
            quo = quo + QW'(ge[i]);
        sub = SUM_W'(quo) * SUM_W'(TICKS_PER_CYC);
        rem = TPOS_W'(sum - sub);
    end
endmodule

// File: rtl/syt_stamp_gen.sv
module syt_stamp_gen
    import syt_pkg::*;
#(
    parameter int CYC_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cyc_stb,
    input  logic [CYC_W-1:0] cyc_count,
    input  logic [2:0]       rate_code,
    input  logic             blocking,
    output logic [SYT_W-1:0] syt,
    output logic             syt_val,
    output logic             syt_none
);
    localparam int QW = $clog2(MAXQ + 1);

    logic             armed;
    logic             adv;
    rate_cfg_t        cfg;
    logic [OFF_W-1:0] nxt_off;
    logic             nxt_in_cyc;
    logic [SUM_W-1:0] dsum;
    logic [QW-1:0]    quo;
    logic [TPOS_W-1:0] rem;
    logic [CNO_W-1:0] cyc_no;

    assign adv = cyc_stb && armed && !start;

    syt_rate_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .rate_code (rate_code),
        .blocking  (blocking),
        .cfg       (cfg)
    );

    syt_offset_track u_trk (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .adv        (adv),
        .fam44      (cfg.fam44),
        .step       (cfg.step),
        .nxt_off    (nxt_off),
        .nxt_in_cyc (nxt_in_cyc)
    );

    assign dsum = SUM_W'(nxt_off) + cfg.delay;

    syt_tick_split #(.QMAX(MAXQ)) u_split (
        .sum (dsum),
        .quo (quo),
        .rem (rem)
    );

    assign cyc_no = cyc_count[CNO_W-1:0] + CNO_W'(quo);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            syt      <= SYT_EMPTY;
            syt_val  <= 1'b0;
            syt_none <= 1'b0;
        end else begin
            if (start)
                armed <= 1'b1;
            syt_val  <= adv && nxt_in_cyc;
            syt_none <= adv && !nxt_in_cyc;
            if (adv)
                syt <= nxt_in_cyc ? {cyc_no, rem} : SYT_EMPTY;
        end
    end
endmodule

// File: rtl/syt_stamp_gen_chk.sv
module syt_stamp_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        cyc_stb,
    input logic        armed,
    input logic [15:0] syt,
    input logic        syt_val,
    input logic        syt_none
);
    assert_flags_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(syt_val && syt_none));

    assert_result_follows_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (syt_val || syt_none) |-> $past(cyc_stb && armed && !start));

    assert_strobe_yields_result_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb && armed && !start) |=> (syt_val || syt_none));

    assert_quiet_until_start_R1: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !(syt_val || syt_none));

    assert_empty_code_R8: assert property (@(posedge clk) disable iff (rst)
        syt_none |-> (syt == 16'hFFFF));

    assert_tick_range_R6: assert property (@(posedge clk) disable iff (rst)
        syt_val |-> (syt[11:0] < 12'd3072));
endmodule

bind syt_stamp_gen syt_stamp_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cyc_stb  (cyc_stb),
    .armed    (armed),
    .syt      (syt),
    .syt_val  (syt_val),
    .syt_none (syt_none)
);

// File: tb/syt_stamp_gen_tb.sv
module syt_stamp_gen_tb;
    localparam int CYC_W = 13;
    localparam int N_SC  = 10;
    localparam int SC_RATE [N_SC] = '{0, 1, 2, 3, 4, 5, 6, 0, 1, 2};
    localparam int SC_BLK  [N_SC] = '{0, 1, 0, 0, 1, 1, 0, 1, 0, 1};
    localparam int SC_NSTB [N_SC] = '{12, 400, 16, 40, 16, 40, 16, 12, 60, 10};
    localparam int SC_CYC0 [N_SC] = '{5, 8180, 100, 0, 7, 8190, 3, 15, 30, 4000};

    logic clk = 0, rst = 1, start = 0, cyc_stb = 0, blocking = 0;
    logic [2:0] rate_code = 0;
    logic [CYC_W-1:0] cyc_count = 0;
    logic [15:0] syt;
    logic syt_val, syt_none;

    int n_cmp = 0, n_bad = 0;
    int m_last, m_phase, m_delay, m_code;

    always #10 clk = ~clk;

    syt_stamp_gen #(.CYC_W(CYC_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cyc_stb(cyc_stb),
        .cyc_count(cyc_count), .rate_code(rate_code), .blocking(blocking),
        .syt(syt), .syt_val(syt_val), .syt_none(syt_none)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int rate_hz(input int c);
        case (c)
            0: return 32000;   1: return 44100;  2: return 48000;
            3: return 88200;   4: return 96000;  5: return 176400;
            default: return 192000;
        endcase
    endfunction

    function automatic int intv(input int c);
        if (c <= 2) return 8;
        if (c <= 4) return 16;
        return 32;
    endfunction

    task automatic model_start(input int code, input int blk);
        m_code  = code;
        m_last  = 3072;
        m_phase = 67;
        m_delay = 8704 + (blk != 0 ? (24576000 * intv(code)) / rate_hz(code) : 0);
    endtask

    task automatic model_step(input int cyc, output int exp_syt, output bit exp_ok);
        int d, ix;
        if (m_last < 3072) begin
            if (m_code % 2 == 1) begin
                ix = m_phase % 13;
                m_last = m_last + 1386 + (((ix != 0 && ix % 4 == 0) || m_phase == 146) ? 1 : 0);
                m_phase = (m_phase == 146) ? 0 : m_phase + 1;
            end else begin
                m_last = m_last + (m_code == 0 ? 3072 : 1024);
            end
        end else begin
            m_last = m_last - 3072;
        end
        exp_ok = (m_last < 3072);
        if (exp_ok) begin
            d = m_last + m_delay;
            exp_syt = (((cyc + d / 3072) << 12) + d % 3072) & 16'hFFFF;
        end else begin
            exp_syt = 16'hFFFF;
        end
    endtask

    task automatic do_start(input int code, input int blk);
        @(negedge clk);
        rate_code = 3'(code);
        blocking  = blk[0];
        start     = 1;
        @(negedge clk);
        start     = 0;
        rate_code = ~3'(code);
        blocking  = ~blk[0];
        model_start(code, blk);
    endtask

    task automatic do_strobe(input int cyc, input string tag);
        int es;
        bit eo;
        @(negedge clk);
        cyc_stb   = 1;
        cyc_count = CYC_W'(cyc);
        @(negedge clk);
        cyc_stb = 0;
        model_step(cyc, es, eo);
        chk({"R2 val ", tag}, int'(syt_val), int'(eo));
        chk({"R2 none ", tag}, int'(syt_none), int'(!eo));
        chk(eo ? {"R6 syt ", tag} : {"R8 syt ", tag}, int'(syt), es);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset syt", int'(syt), 16'hFFFF);
        chk("R1 reset val", int'(syt_val), 0);
        chk("R1 reset none", int'(syt_none), 0);

        // R1: strobe before any start yields nothing
        cyc_stb = 1;
        @(negedge clk);
        cyc_stb = 0;
        chk("R1 pre-start val", int'(syt_val), 0);
        chk("R1 pre-start none", int'(syt_none), 0);
        chk("R1 pre-start syt", int'(syt), 16'hFFFF);

        // R7 R3 hand check: 48 kHz plain, first strobe offset 0 -> 0x7A00
        do_start(2, 0);
        do_strobe(5, "R3 R7 hand48");
        chk("R7 hand48 value", int'(syt), 16'h7A00);

        // R5 hand check: 44.1 kHz plain, second strobe offset 1386 -> 0x936A
        do_start(1, 0);
        do_strobe(5, "R5 first");
        do_strobe(6, "R5 second");
        chk("R5 hand44 value", int'(syt), 16'h936A);

        // R2: strobe coincident with start is dropped
        @(negedge clk);
        rate_code = 3'd0;
        blocking  = 0;
        start     = 1;
        cyc_stb   = 1;
        @(negedge clk);
        start   = 0;
        cyc_stb = 0;
        chk("R2 start+strobe val", int'(syt_val), 0);
        chk("R2 start+strobe none", int'(syt_none), 0);
        model_start(0, 0);
        do_strobe(9, "R3 after dropped strobe");

        // Scenario table: rate and mode toggled after start (R10)
        for (int s = 0; s < N_SC; s++) begin
            string tag;
            tag = (SC_RATE[s] % 2 == 1) ? "R5" : "R4";
            if (SC_BLK[s] != 0) tag = {tag, " R7"};
            if (SC_CYC0[s] > 8000) tag = {tag, " R9"};
            tag = {tag, " R10 R3"};
            do_start(SC_RATE[s], SC_BLK[s]);
            for (int i = 0; i < SC_NSTB[s]; i++) begin
                do_strobe((SC_CYC0[s] + i) % (1 << CYC_W), tag);
                if (i % 4 == 3) begin
                    @(negedge clk);
                    chk({"R2 idle val ", tag}, int'(syt_val), 0);
                    chk({"R2 idle none ", tag}, int'(syt_none), 0);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule